// File: doc/BRIEF.md
# Inclusive Shared-Cache Tag and Sharer Directory

This block holds the tags and per-block core-presence vectors of a set-associative shared last-level cache. The cache is kept inclusive of several private per-core caches. Cores send two kinds of request over a valid/ready channel: a fill, when a core loads a block, and a drop notice, when a core discards a block. Each stored block carries one presence bit per core. A fill sets the requester's bit. A drop notice clears it.

When a fill misses, the directory needs a way in the indexed set. It takes any way that no core holds (an invalid way counts as unheld). A tree pseudo-LRU decides among several unheld ways. Only when every way of the set is held by some core does it pick the pseudo-LRU way and issue a back-invalidate request. That request carries the victim's block address and its presence vector. Further requests are held off until the acknowledge arrives. The new tag is then installed.

Top module: `incl_sharer_dir`

## Requirements
- R1: After reset, no way holds a valid tag and every presence vector is zero. `req_ready` is 1, `rcl_valid` is 0 and `rsp_valid` is 0, and the first fill into a set misses and lands in way 0.
- R2: The set is the block address modulo SETS, which is the low log2(SETS) bits. The tag is the remaining upper bits. A request reads and changes only its own set.
- R3: A fill that hits answers with `rsp_hit`=1 and the matching way. It sets the requester's presence bit and allocates nothing.
- R4: A drop notice that hits answers with `rsp_hit`=1 and the way, and clears only the requester's bit. A drop notice from a core that does not hold the block leaves the vector unchanged. A drop notice that misses answers with `rsp_hit`=0 and changes nothing.
- R5: The response to an accepted request appears on `rsp_valid` in the cycle after acceptance, unless a back-invalidate is started. A miss answers with `rsp_hit`=0 and the chosen way. The new block's vector holds only the requester's bit (bit i stands for core i). `req_op` is 0 for a fill and 1 for a drop notice.
- R6: On a fill miss, a way whose vector is all zero, or an invalid way, is always chosen before any held way, even when a held way is the pseudo-LRU one. A back-invalidate is issued only when every way of the set is held.
- R7: The replacement state holds WAYS-1 bits per set in a binary tree. Node n has children 2n+1 and 2n+2. A node bit of 0 steers toward the lower-numbered half, and a touch sets each node on the path to point away from the touched way. A fill hit or an install touches its way; a drop notice does not. The walk prefers the pointed half, but enters the other half when the pointed half has no unheld way.
- R8: A back-invalidate raises `rcl_valid` in the cycle after the fill is accepted. The victim address is {victim tag, set} and the sharer vector is the victim's vector. Both stay stable until `rcl_ack`, and `req_ready` stays 0 for the whole time.
- R9: The cycle after `rcl_ack` is sampled, `rcl_valid` falls and the pending fill answers as a miss in the victim's way. The replaced block then misses on later requests.
- R10: When every core holds at most one block per set and WAYS exceeds NUM_CORES, no back-invalidate ever occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_core | input | $clog2(NUM_CORES) | Requesting core |
| req_op | input | 1 | 0 fill, 1 drop notice |
| req_addr | input | ADDR_W | Block address |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_hit | output | 1 | The request's tag was present |
| rsp_way | output | $clog2(WAYS) | Way hit or allocated |
| rcl_valid | output | 1 | Back-invalidate pending |
| rcl_addr | output | ADDR_W | Block address to invalidate |
| rcl_sharers | output | NUM_CORES | Cores holding the victim |
| rcl_ack | input | 1 | Cores have dropped the victim |

## Verification
Two functions can fall in the same cycle: completing a back-invalidate with its acknowledge, and a new request that has been held waiting during the stall. The bench keeps the next fill asserted while the back-invalidate is outstanding, so the acknowledge edge and that request meet. It then checks that the request is not taken on the acknowledge edge. The stalled fill's response must come first, and the waiting fill must see the freshly installed tag. That waiting fill targets the block just invalidated and therefore triggers a second back-invalidate, whose sharer vector and address are compared.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic {
        OP_FILL = 1'b0,
        OP_DROP = 1'b1
    } dir_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RECALL = 1'b1
    } dir_st_e;

endpackage

// File: rtl/dir_set_probe.sv
module dir_set_probe #(
    parameter int WAYS      = 4,
    parameter int TAG_W     = 8,
    parameter int NUM_CORES = 2,
    localparam int WIDX     = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]                valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0]     tag_row,
    input  logic [WAYS-1:0][NUM_CORES-1:0] shr_row,
    input  logic [TAG_W-1:0]               look_tag,
    output logic                           hit,
    output logic [WIDX-1:0]                hit_way,
    output logic [WAYS-1:0]                free_mask
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w]     = valid_row[w] && (tag_row[w] == look_tag);
        assign free_mask[w] = !valid_row[w] || (shr_row[w] == '0);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WIDX'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/dir_plru_pick.sv
module dir_plru_pick #(
    parameter int WAYS  = 4,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] tree,
    input  logic [WAYS-1:0] mask,
    output logic [WIDX-1:0] way
);
    always_comb begin
        int node;
        int base;
        int half;
        logic lo_any;
        logic hi_any;
        logic go_hi;
        node = 0;
        base = 0;
        for (int l = 0; l < WIDX; l++) begin
            half   = WAYS >> (l + 1);
            lo_any = 1'b0;
            hi_any = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (w >= base && w < base + half)            lo_any = lo_any | mask[w];
                if (w >= base + half && w < base + 2 * half) hi_any = hi_any | mask[w];
            end
            go_hi = tree[node] ? hi_any : !lo_any;
            if (go_hi) base = base + half;
            node = 2 * node + (go_hi ? 2 : 1);
        end
        way = base[WIDX-1:0];
    end
endmodule

// File: rtl/dir_plru_touch.sv
module dir_plru_touch #(
    parameter int WAYS  = 4,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] tree_in,
    input  logic [WIDX-1:0] way,
    output logic [WAYS-2:0] tree_out
);
    always_comb begin
        int node;
        logic dir;
        tree_out = tree_in;
        node     = 0;
        for (int l = 0; l < WIDX; l++) begin
            dir            = way[WIDX-1-l];
            tree_out[node] = !dir;
            node           = 2 * node + (dir ? 2 : 1);
        end
    end
endmodule

// File: rtl/incl_sharer_dir.sv
module incl_sharer_dir
    import dir_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int ADDR_W    = 10,
    localparam int CID_W    = $clog2(NUM_CORES),
    localparam int WIDX     = $clog2(WAYS),
    localparam int SET_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - SET_W,
    localparam int PL_W     = WAYS - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CID_W-1:0]     req_core,
    input  logic                 req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WIDX-1:0]      rsp_way,
    output logic                 rcl_valid,
    output logic [ADDR_W-1:0]    rcl_addr,
    output logic [NUM_CORES-1:0] rcl_sharers,
    input  logic                 rcl_ack
);
    typedef struct packed {
        dir_st_e                                   st;
        logic [SETS-1:0][WAYS-1:0]                 vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]      tag;
        logic [SETS-1:0][WAYS-1:0][NUM_CORES-1:0]  shr;
        logic [SETS-1:0][PL_W-1:0]                 plru;
        logic [SET_W-1:0]                          p_set;
        logic [TAG_W-1:0]                          p_tag;
        logic [CID_W-1:0]                          p_core;
        logic [WIDX-1:0]                           p_way;
        logic                                      rcl_v;
        logic [ADDR_W-1:0]                         rcl_a;
        logic [NUM_CORES-1:0]                      rcl_s;
        logic                                      rsp_v;
        logic                                      rsp_h;
        logic [WIDX-1:0]                           rsp_w;
    } dir_state_t;

    dir_state_t q, d;

    logic [SET_W-1:0] r_set;
    logic [TAG_W-1:0] r_tag;
    logic             hit;
    logic [WIDX-1:0]  hit_way;
    logic [WAYS-1:0]  free_mask;
    logic [WAYS-1:0]  pick_mask;
    logic [WIDX-1:0]  victim;
    logic [WIDX-1:0]  touch_way;
    logic [PL_W-1:0]  touch_in;
    logic [PL_W-1:0]  touch_out;

    assign r_set = req_addr[SET_W-1:0];
    assign r_tag = req_addr[ADDR_W-1:SET_W];

    dir_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W), .NUM_CORES(NUM_CORES)) u_probe (
        .valid_row (q.vld[r_set]),
        .tag_row   (q.tag[r_set]),
        .shr_row   (q.shr[r_set]),
        .look_tag  (r_tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .free_mask (free_mask)
    );

    // Unheld ways first; every way when all are held.
    assign pick_mask = (|free_mask) ? free_mask : '1;

    dir_plru_pick #(.WAYS(WAYS)) u_pick (
        .tree (q.plru[r_set]),
        .mask (pick_mask),
        .way  (victim)
    );

    assign touch_way = (q.st == ST_RECALL) ? q.p_way : (hit ? hit_way : victim);
    assign touch_in  = (q.st == ST_RECALL) ? q.plru[q.p_set] : q.plru[r_set];

    dir_plru_touch #(.WAYS(WAYS)) u_touch (
        .tree_in  (touch_in),
        .way      (touch_way),
        .tree_out (touch_out)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dir_op_e'(req_op) == OP_FILL) begin
                        if (hit) begin
                            d.shr[r_set][hit_way][req_core] = 1'b1;
                            d.plru[r_set] = touch_out;
                            d.rsp_v = 1'b1;
                            d.rsp_h = 1'b1;
                            d.rsp_w = hit_way;
                        end else if (|free_mask) begin
                            d.vld[r_set][victim] = 1'b1;
                            d.tag[r_set][victim] = r_tag;
                            d.shr[r_set][victim] = '0;
                            d.shr[r_set][victim][req_core] = 1'b1;
                            d.plru[r_set] = touch_out;
                            d.rsp_v = 1'b1;
                            d.rsp_h = 1'b0;
                            d.rsp_w = victim;
                        end else begin
                            d.st     = ST_RECALL;
                            d.p_set  = r_set;
                            d.p_tag  = r_tag;
                            d.p_core = req_core;
                            d.p_way  = victim;
                            d.rcl_v  = 1'b1;
                            d.rcl_a  = {q.tag[r_set][victim], r_set};
                            d.rcl_s  = q.shr[r_set][victim];
                        end
                    end else begin
                        d.rsp_v = 1'b1;
                        d.rsp_h = hit;
                        d.rsp_w = hit ? hit_way : '0;
                        if (hit) d.shr[r_set][hit_way][req_core] = 1'b0;
                    end
                end
            end
            ST_RECALL: begin
                if (rcl_ack) begin
                    d.st = ST_IDLE;
                    d.rcl_v = 1'b0;
                    d.vld[q.p_set][q.p_way] = 1'b1;
                    d.tag[q.p_set][q.p_way] = q.p_tag;
                    d.shr[q.p_set][q.p_way] = '0;
                    d.shr[q.p_set][q.p_way][q.p_core] = 1'b1;
                    d.plru[q.p_set] = touch_out;
                    d.rsp_v = 1'b1;
                    d.rsp_h = 1'b0;
                    d.rsp_w = q.p_way;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign rsp_valid   = q.rsp_v;
    assign rsp_hit     = q.rsp_h;
    assign rsp_way     = q.rsp_w;
    assign rcl_valid   = q.rcl_v;
    assign rcl_addr    = q.rcl_a;
    assign rcl_sharers = q.rcl_s;
endmodule

// File: rtl/dir_chk.sv
module dir_chk #(
    parameter int NUM_CORES = 2,
    parameter int WAYS      = 4,
    parameter int ADDR_W    = 10,
    localparam int CID_W    = $clog2(NUM_CORES),
    localparam int WIDX     = $clog2(WAYS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rcl_valid,
    input logic [ADDR_W-1:0]    rcl_addr,
    input logic [NUM_CORES-1:0] rcl_sharers,
    input logic                 rcl_ack
);
    a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_valid |-> !req_ready);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_valid && !rcl_ack |=> rcl_valid && $stable(rcl_addr) && $stable(rcl_sharers));

    a_r6_held_victim: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_valid |-> rcl_sharers != '0);

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid || rcl_valid);

    a_r9_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_valid && rcl_ack |=> !rcl_valid && rsp_valid && !rsp_hit);

    a_r5_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready) || $past(rcl_valid && rcl_ack));
endmodule

bind incl_sharer_dir dir_chk #(
    .NUM_CORES (NUM_CORES),
    .WAYS      (WAYS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rcl_valid   (rcl_valid),
    .rcl_addr    (rcl_addr),
    .rcl_sharers (rcl_sharers),
    .rcl_ack     (rcl_ack)
);

// File: tb/incl_sharer_dir_bench.sv
module incl_sharer_dir_bench;
    localparam int NC = 2;
    localparam int NS = 4;
    localparam int NW = 4;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [0:0]    req_core = '0;
    logic          req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [1:0]    rsp_way;
    logic          rcl_valid;
    logic [AW-1:0] rcl_addr;
    logic [NC-1:0] rcl_sharers;
    logic          rcl_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int recalls = 0;
    bit done = 1'b0;

    typedef struct { bit hit; int way; string tag; } exp_t;
    exp_t exp_q[$];
    int   rq_addr[$];
    int   rq_shr[$];
    string rq_tag[$];

    always #4 clk = ~clk;

    incl_sharer_dir #(.NUM_CORES(NC), .SETS(NS), .WAYS(NW), .ADDR_W(AW)) u_incl_sharer_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_op(req_op), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rcl_valid(rcl_valid), .rcl_addr(rcl_addr), .rcl_sharers(rcl_sharers),
        .rcl_ack(rcl_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: called at a negedge; pushes the expected response, then holds the request until taken.
    task automatic send(input int core, input bit op, input int addr,
                        input bit ehit, input int eway, input string req);
        exp_t e;
        e.hit = ehit; e.way = eway; e.tag = req;
        exp_q.push_back(e);
        req_valid = 1'b1; req_core = core[0:0]; req_op = op; req_addr = addr[AW-1:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_recall(input int addr, input int shr, input string req);
        rq_addr.push_back(addr); rq_shr.push_back(shr); rq_tag.push_back(req);
    endtask

    // Monitor: compares responses against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_hit == e.hit, e.tag, int'(rsp_hit), int'(e.hit));
                    if (e.way >= 0) check(int'(rsp_way) == e.way, e.tag, int'(rsp_way), e.way);
                end
            end
        end
    end

    // Recall responder: compares back-invalidates, checks the stall, acknowledges after a delay.
    initial begin
        forever begin
            @(negedge clk);
            if (rcl_valid) begin
                recalls++;
                if (rq_addr.size() == 0) begin
                    check(1'b0, "R10 R6 unexpected back-invalidate", int'(rcl_addr), 0);
                end else begin
                    int a; int s; string t;
                    a = rq_addr.pop_front(); s = rq_shr.pop_front(); t = rq_tag.pop_front();
                    check(int'(rcl_addr) == a, {t, " addr"}, int'(rcl_addr), a);
                    check(int'(rcl_sharers) == s, {t, " sharers"}, int'(rcl_sharers), s);
                end
                check(req_ready == 1'b0, "R8 stall while pending", int'(req_ready), 0);
                repeat (2) @(negedge clk);
                check(rcl_valid == 1'b1 && req_ready == 1'b0, "R8 held until ack", int'(rcl_valid), 1);
                rcl_ack = 1'b1;
                @(negedge clk);
                rcl_ack = 1'b0;
                check(rcl_valid == 1'b0, "R9 drop after ack", int'(rcl_valid), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base_rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(rcl_valid == 1'b0, "R1 no recall after reset", int'(rcl_valid), 0);
        check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

        send(0, 0, 'h000, 0, 0, "R1 first fill way0");
        send(1, 0, 'h004, 0, 2, "R7 unheld pick way2");
        send(1, 0, 'h000, 1, 0, "R3 fill hit way0");
        send(0, 0, 'h008, 0, 3, "R7 pick way3");
        send(0, 0, 'h00C, 0, 1, "R5 last free way1");
        send(1, 1, 'h004, 1, 2, "R4 drop hit way2");
        send(1, 0, 'h010, 0, 2, "R4 freed way reused");
        send(0, 1, 'h00C, 1, 1, "R4 drop hit way1");
        send(0, 0, 'h014, 0, 1, "R6 unheld over lru way1");
        send(0, 1, 'h3FC, 0, -1, "R4 drop miss");
        send(0, 0, 'h001, 0, 0, "R2 other set fresh");
        send(1, 0, 'h005, 0, 2, "R2 other set way2");

        expect_recall('h008, 'b01, "R8 first recall");
        send(1, 0, 'h018, 0, 3, "R9 install after ack way3");
        expect_recall('h000, 'b11, "R8 two sharers");
        send(1, 0, 'h008, 0, 0, "R9 recalled block misses");
        expect_recall('h010, 'b10, "R8 core1 sharer");
        send(0, 0, 'h000, 0, 2, "R9 recalled tag0 misses");
        send(0, 1, 'h018, 1, 3, "R4 drop by non-holder");
        expect_recall('h014, 'b01, "R4 non-holder left bit set");
        send(0, 0, 'h01C, 0, 1, "R7 lru recall way1");
        send(1, 0, 'h008, 1, 0, "R3 hit after install");

        base_rc = recalls;
        for (int i = 0; i < 40; i++) begin
            int a;
            a = ((16 + i) << 2) | 2;
            if (i >= 2) send(i % 2, 1, ((16 + i - 2) << 2) | 2, 1, -1, "R10 drop before fill");
            send(i % 2, 0, a, 0, -1, "R10 fill miss");
        end
        repeat (6) @(negedge clk);
        check(recalls == base_rc, "R10 no back-invalidate", recalls - base_rc, 0);
        check(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
        check(rq_addr.size() == 0, "R8 all recalls seen", rq_addr.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule